// File: doc/BRIEF.md
# AES Equivalent-Inverse Decryption Round

This block performs one round of AES decryption in the equivalent inverse cipher form on a 128-bit state. The round is applied in a fixed order. The state's rows are rotated back, then every byte passes through the inverse substitution. Next, each column is multiplied by the inverse mixing matrix. Finally the round key is XORed in as the last step. A last-round select skips the column mixing, which gives the variant used for the final decryption round. Key expansion, the inverse key schedule transform and round sequencing are left to the surrounding logic.

The 128-bit result is also merged into a wider destination register value. The caller supplies the old upper lane of that register. A merge mode decides whether the upper lane keeps its old contents or is cleared. One register stage captures the result whenever the input strobe is high. The result then appears one cycle later, together with a valid flag.

Top module: `aes_inv_round`

## Requirements
- R1: While reset is asserted, and after it is released until the first strobe, `out_valid` is 0 and `out_result` and `out_dest` are all zeros.
- R2: `out_valid` is 1 exactly in the cycle after a cycle with `in_valid` high. When `in_valid` is low, `out_result` and `out_dest` keep their values.
- R3: With `in_last` = 0, `out_result` equals InvMixColumns(InvSubBytes(InvShiftRows(state))) XOR key, in that order.
- R4: State byte i occupies bits 8i+7:8i. Byte 4c+r is row r of column c, so byte 0 is row 0 of the first column.
- R5: The inverse row shift sends byte (row r, column c) to (row r, column (c+r) mod 4). Row 0 does not move.
- R6: The inverse substitution maps byte b to the multiplicative inverse, modulo x^8+x^4+x^3+x+1, of b' = rotl(b,1)^rotl(b,3)^rotl(b,6)^0x05, with 0 mapped to 0. Examples: 0x63 maps to 0x00, 0x00 to 0x52 and 0x7c to 0x01.
- R7: Column mixing gives output row r as 0e·a[r] ^ 0b·a[r+1] ^ 0d·a[r+2] ^ 09·a[r+3], with indices taken mod 4.
- R8: With `in_last` = 1, column mixing is skipped: `out_result` = InvSubBytes(InvShiftRows(state)) XOR key.
- R9: With `in_zero_upper` = 0, the upper `UPPER_W` bits of `out_dest` equal the `in_upper_old` captured with the strobe.
- R10: With `in_zero_upper` = 1, the upper `UPPER_W` bits of `out_dest` are zero. In both merge modes, the low 128 bits equal `out_result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe: capture a round result this cycle |
| in_state | input | 128 | Round input state |
| in_key | input | 128 | Round key |
| in_last | input | 1 | 1 = final round (no column mixing) |
| in_zero_upper | input | 1 | 1 = clear upper destination lane, 0 = keep it |
| in_upper_old | input | UPPER_W | Prior upper lane of the destination |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| out_result | output | 128 | Round result |
| out_dest | output | UPPER_W+128 | Merged wide destination |

## Verification
The bench builds the block with the default `UPPER_W` of 128. This gives a 256-bit merged destination, so a full-width upper lane can be checked for being kept and for being cleared, with patterns that differ in every byte. Known constant states, such as all 0x63 and all 0x00, reach the substitution endpoints directly. A single marked byte exposes the row-shift position and the matrix coefficients, and pseudo-random states are compared against a separately built model in both round variants.

// File: rtl/aes_inv_pkg.sv
package aes_inv_pkg;

    localparam int BYTE_W  = 8;
    localparam int N_ROW   = 4;
    localparam int N_COL   = 4;
    localparam int N_BYTE  = N_ROW * N_COL;
    localparam int STATE_W = N_BYTE * BYTE_W;
    localparam int COL_W   = N_ROW * BYTE_W;

    typedef logic [BYTE_W-1:0] byte_t;

    // multiply by x modulo x^8+x^4+x^3+x+1
    function automatic byte_t gf_xtime(input byte_t a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t acc;
        byte_t sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_xtime(sh);
        end
        return acc;
    endfunction

    // a^254 = a^-1 for a != 0, and 0 for a == 0
    function automatic byte_t gf_inv(input byte_t a);
        byte_t pw;
        byte_t res;
        pw  = a;
        res = 8'h01;
        for (int i = 1; i < BYTE_W; i++) begin
            pw  = gf_mul(pw, pw);
            res = gf_mul(res, pw);
        end
        return res;
    endfunction

    function automatic byte_t rotl8(input byte_t a, input int n);
        return byte_t'((a << n) | (a >> (BYTE_W - n)));
    endfunction

    function automatic byte_t inv_affine(input byte_t b);
        return rotl8(b, 1) ^ rotl8(b, 3) ^ rotl8(b, 6) ^ 8'h05;
    endfunction

endpackage

// File: rtl/aes_inv_sbox.sv
module aes_inv_sbox
    import aes_inv_pkg::*;
(
    input  logic [BYTE_W-1:0] sb_in,
    output logic [BYTE_W-1:0] sb_out
);

    byte_t pre_inv;

    always_comb begin
        pre_inv = inv_affine(sb_in);
        sb_out  = gf_inv(pre_inv);
    end

endmodule

// File: rtl/aes_inv_mixcol.sv
module aes_inv_mixcol
    import aes_inv_pkg::*;
(
    input  logic [COL_W-1:0] col_in,
    output logic [COL_W-1:0] col_out
);

    byte_t m9  [N_ROW];
    byte_t mb  [N_ROW];
    byte_t md  [N_ROW];
    byte_t me  [N_ROW];

    for (genvar r = 0; r < N_ROW; r++) begin : g_coef
        byte_t a, x2, x4, x8;
        always_comb begin
            a     = col_in[BYTE_W*r +: BYTE_W];
            x2    = gf_xtime(a);
            x4    = gf_xtime(x2);
            x8    = gf_xtime(x4);
            m9[r] = x8 ^ a;
            mb[r] = x8 ^ x2 ^ a;
            md[r] = x8 ^ x4 ^ a;
            me[r] = x8 ^ x4 ^ x2;
        end
    end

    for (genvar r = 0; r < N_ROW; r++) begin : g_row
        assign col_out[BYTE_W*r +: BYTE_W] = me[r]
                                           ^ mb[(r + 1) % N_ROW]
                                           ^ md[(r + 2) % N_ROW]
                                           ^ m9[(r + 3) % N_ROW];
    end

endmodule

// File: rtl/aes_inv_round.sv
module aes_inv_round
    import aes_inv_pkg::*;
#(
    parameter int UPPER_W = 128
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [STATE_W-1:0]         in_state,
    input  logic [STATE_W-1:0]         in_key,
    input  logic                       in_last,
    input  logic                       in_zero_upper,
    input  logic [UPPER_W-1:0]         in_upper_old,
    output logic                       out_valid,
    output logic [STATE_W-1:0]         out_result,
    output logic [UPPER_W+STATE_W-1:0] out_dest
);

    localparam int DEST_W = UPPER_W + STATE_W;

    logic [STATE_W-1:0] shifted;
    logic [STATE_W-1:0] subbed;
    logic [STATE_W-1:0] mixed;
    logic [STATE_W-1:0] round_next;
    logic [STATE_W-1:0] result_q;
    logic [UPPER_W-1:0] upper_q;
    logic               valid_q;

    // inverse row shift: (r, c) moves to (r, (c+r) mod 4)
    for (genvar c = 0; c < N_COL; c++) begin : g_col_shift
        for (genvar r = 0; r < N_ROW; r++) begin : g_row_shift
            assign shifted[BYTE_W*(N_ROW*c + r) +: BYTE_W] =
                in_state[BYTE_W*(N_ROW*((c - r + N_COL) % N_COL) + r) +: BYTE_W];
        end
    end

    for (genvar i = 0; i < N_BYTE; i++) begin : g_sbox
        aes_inv_sbox u_sbox (
            .sb_in  (shifted[BYTE_W*i +: BYTE_W]),
            .sb_out (subbed[BYTE_W*i +: BYTE_W])
        );
    end

    for (genvar c = 0; c < N_COL; c++) begin : g_mix
        aes_inv_mixcol u_mix (
            .col_in  (subbed[COL_W*c +: COL_W]),
            .col_out (mixed[COL_W*c +: COL_W])
        );
    end

    always_comb begin
        round_next = (in_last ? subbed : mixed) ^ in_key;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q  <= 1'b0;
            result_q <= '0;
            upper_q  <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                result_q <= round_next;
                upper_q  <= in_zero_upper ? '0 : in_upper_old;
            end
        end
    end

    always_comb begin
        out_valid  = valid_q;
        out_result = result_q;
        out_dest   = {upper_q, result_q};
    end

    // R2: strobe in one cycle gives valid in the next
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2: no strobe, no valid, result held
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_result) && $stable(out_dest)));
    // R9: legacy merge keeps the captured upper lane
    a_r9_keep_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_zero_upper) |=> (out_dest[DEST_W-1:STATE_W] == $past(in_upper_old)));
    // R10: zeroing merge clears the upper lane and the low lane mirrors the result
    a_r10_zero_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_zero_upper) |=> (out_dest[DEST_W-1:STATE_W] == '0
                                         && out_dest[STATE_W-1:0] == out_result));
    // R7: matrix coefficients sum to 1, so column XOR is preserved by the mixing
    for (genvar c = 0; c < N_COL; c++) begin : g_chk_mix
        a_r7_col_parity: assert property (@(posedge clk) disable iff (!rst_n)
            (mixed[COL_W*c+0 +: 8] ^ mixed[COL_W*c+8 +: 8] ^ mixed[COL_W*c+16 +: 8] ^ mixed[COL_W*c+24 +: 8])
            == (subbed[COL_W*c+0 +: 8] ^ subbed[COL_W*c+8 +: 8] ^ subbed[COL_W*c+16 +: 8] ^ subbed[COL_W*c+24 +: 8]));
    end

endmodule

// File: tb/sim_aes_inv_round.sv
module sim_aes_inv_round;

    localparam int UW = 128;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic [127:0]   in_state = '0;
    logic [127:0]   in_key = '0;
    logic           in_last = 1'b0;
    logic           in_zero_upper = 1'b0;
    logic [UW-1:0]  in_upper_old = '0;
    logic           out_valid;
    logic [127:0]   out_result;
    logic [UW+127:0] out_dest;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] isb_tab [256];
    logic [31:0] lfsr = 32'h1234_5678;

    always #5 clk = ~clk;

    aes_inv_round #(.UPPER_W(UW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_state(in_state), .in_key(in_key), .in_last(in_last),
        .in_zero_upper(in_zero_upper), .in_upper_old(in_upper_old),
        .out_valid(out_valid), .out_result(out_result), .out_dest(out_dest)
    );

    // ---------- reference model ----------
    function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] p = '0;
        for (int i = 0; i < 8; i++) if (b[i]) p ^= 16'(a) << i;
        for (int i = 15; i >= 8; i--) if (p[i]) p ^= 16'h011b << (i - 8);
        return p[7:0];
    endfunction

    function automatic logic [7:0] m_rl(input logic [7:0] a, input int n);
        return (a << n) | (a >> (8 - n));
    endfunction

    task automatic build_table();
        for (int x = 0; x < 256; x++) begin
            logic [7:0] inv = 8'h00;
            logic [7:0] s;
            for (int y = 1; y < 256; y++)
                if (m_mul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
            s = inv ^ m_rl(inv, 1) ^ m_rl(inv, 2) ^ m_rl(inv, 3) ^ m_rl(inv, 4) ^ 8'h63;
            isb_tab[s] = 8'(x);
        end
    endtask

    function automatic logic [127:0] model(input logic [127:0] st, input logic [127:0] k, input logic last);
        logic [7:0] b [16];
        logic [7:0] t [16];
        logic [127:0] o;
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++)
                t[4*((c + r) % 4) + r] = st[8*(4*c + r) +: 8];
        for (int i = 0; i < 16; i++) b[i] = isb_tab[t[i]];
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++)
                t[4*c + r] = last ? b[4*c + r] :
                    m_mul(8'h0e, b[4*c + r]) ^ m_mul(8'h0b, b[4*c + (r+1)%4]) ^
                    m_mul(8'h0d, b[4*c + (r+2)%4]) ^ m_mul(8'h09, b[4*c + (r+3)%4]);
        for (int i = 0; i < 16; i++) o[8*i +: 8] = t[i];
        return o ^ k;
    endfunction

    function automatic logic [127:0] rnd128();
        logic [127:0] v;
        for (int i = 0; i < 4; i++) begin
            lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
            v[32*i +: 32] = lfsr;
        end
        return v;
    endfunction

    // ---------- helpers ----------
    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [127:0] st, input logic [127:0] k, input logic last,
                         input logic zu, input logic [UW-1:0] up);
        @(negedge clk);
        in_state = st; in_key = k; in_last = last; in_zero_upper = zu; in_upper_old = up;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // ---------- scenarios ----------
    task automatic t_reset();
        chk("R1 valid in reset", 256'(out_valid), 256'd0);
        chk("R1 dest in reset", out_dest, 256'd0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", 256'(out_valid), 256'd0);
        chk("R1 result after reset", 256'(out_result), 256'd0);
    endtask

    task automatic t_constants();
        logic [127:0] k = 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0;
        apply({16{8'h63}}, k, 1'b0, 1'b1, '0);
        chk("R2 valid after strobe", 256'(out_valid), 256'd1);
        chk("R6 0x63 maps to 0 (full round)", 256'(out_result), 256'(k));
        apply({16{8'h00}}, k, 1'b0, 1'b1, '0);
        chk("R3 all-zero state full round", 256'(out_result), 256'({16{8'h52}} ^ k));
        apply({16{8'h00}}, k, 1'b1, 1'b1, '0);
        chk("R8 all-zero state last round", 256'(out_result), 256'({16{8'h52}} ^ k));
    endtask

    task automatic t_probe();
        logic [127:0] st = {16{8'h63}};
        st[8*1 +: 8] = 8'h7c;   // R4: byte 1 is row 1 of column 0
        apply(st, '0, 1'b1, 1'b1, '0);
        chk("R5 row1 byte moves to column1 (last)", 256'(out_result), 256'(128'h01 << 40));
        apply(st, '0, 1'b0, 1'b1, '0);
        chk("R7 matrix column for row1 input", 256'(out_result), 256'(128'h0d090e0b << 32));
        st = {16{8'h63}};
        st[8*15 +: 8] = 8'h7c; // row 3 column 3 -> column 2, byte 11
        apply(st, '0, 1'b1, 1'b1, '0);
        chk("R5 row3 rotates by three", 256'(out_result), 256'(128'h01 << 88));
    endtask

    task automatic t_model();
        for (int n = 0; n < 12; n++) begin
            logic [127:0] st = rnd128();
            logic [127:0] k = rnd128();
            logic last = n[0];
            apply(st, k, last, 1'b1, '0);
            chk(last ? "R8 random last round" : "R3 random full round",
                256'(out_result), 256'(model(st, k, last)));
        end
    endtask

    task automatic t_merge();
        logic [127:0] st = rnd128();
        logic [127:0] k = rnd128();
        logic [UW-1:0] up = 128'hfedcba98_76543210_0123_4567_89ab_cdef;
        apply(st, k, 1'b0, 1'b0, up);
        chk("R9 upper lane kept", out_dest, {up, model(st, k, 1'b0)});
        apply(st, k, 1'b0, 1'b1, up);
        chk("R10 upper lane cleared", out_dest, {128'd0, model(st, k, 1'b0)});
    endtask

    task automatic t_hold();
        logic [255:0] snap;
        snap = out_dest;
        @(negedge clk);
        in_state = rnd128(); in_key = rnd128(); in_upper_old = '1; in_zero_upper = 1'b0;
        @(negedge clk);
        chk("R2 no valid without strobe", 256'(out_valid), 256'd0);
        chk("R2 dest held without strobe", out_dest, snap);
    endtask

    initial begin
        build_table();
        t_reset();
        t_constants();
        t_probe();
        t_model();
        t_merge();
        t_hold();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule